// File: doc/BRIEF.md
# Timer Compare Output Unit

This block sits beside a free-running 16-bit timer and compares the timer count against a programmable 16-bit compare value. When the count reaches that value, the unit acts according to a 4-bit mode code. It can drive a compare output latch high or low. It can raise only an interrupt flag. It can also issue a trigger that clears the timer and asks an ADC to start a conversion, which turns the compare value into a programmable timer period.

When a pin-driving mode is selected, the latch is preset at once to the level opposite the one the match will produce. Software reaches three registers through a small write port. Address 0 holds the mode code, address 1 holds the compare value, and address 2 clears the interrupt flag when a one is written to it. A sleep input freezes the unit together with the timer. The latch keeps driving its last level during sleep, and operation carries on from the frozen state on wake.

The timer clear output is a synchronous clear request. It is not a wrap of the timer, so the timer's own overflow flag stays untouched when the trigger fires.

Top module: `cmp_unit`

## Requirements
- R1: After reset the mode is off, and cmp_out_o, irq_flag_o, tmr_clr_o and adc_start_o are all 0.
- R2: Writing mode code 4'b1000 (drive high on match) to address 0 forces cmp_out_o low on the next cycle. A later match sets it high.
- R3: Writing mode code 4'b1001 (drive low on match) to address 0 forces cmp_out_o high on the next cycle. A later match sets it low.
- R4: With mode code 4'b1010 (interrupt only), neither entering the mode nor a match changes cmp_out_o. The match sets irq_flag_o.
- R5: With mode code 4'b1011 (special event), a match drives tmr_clr_o high for exactly one cycle, in the cycle after the match. cmp_out_o is not changed by entering the mode or by the match.
- R6: In mode 4'b1011, adc_start_o pulses together with tmr_clr_o only if adc_en_i is high during the match cycle. Otherwise it stays 0.
- R7: Code 4'b0000 and every code other than 4'b1000 to 4'b1011 mean off. Writing such a code forces cmp_out_o low. In the off state a match sets no flag and produces no pulse.
- R8: A match is the first cycle in which tmr_i equals the compare value (address 1, bits 15:0) while a mode is active. The match sets irq_flag_o one cycle later in every active mode. The flag stays set until a write to address 2 with bit 0 = 1. If a set and a clear happen in the same cycle, the set wins.
- R9: If tmr_i stays equal to the compare value for several cycles, only one event results. Each pulse lasts a single cycle and the flag is set only once.
- R10: While sleep_i is high, matches and register writes have no effect and all outputs hold. After sleep_i falls, a pending equality is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze unit state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 compare, 2 flag clear |
| wr_data_i | input | 16 | Register write data |
| tmr_i | input | 16 | Current timer count |
| adc_en_i | input | 1 | ADC is enabled and may be started |
| tmr_clr_o | output | 1 | One-cycle timer clear request |
| adc_start_o | output | 1 | One-cycle ADC conversion start |
| irq_flag_o | output | 1 | Compare interrupt flag |
| cmp_out_o | output | 1 | Compare output latch |

## Verification
The hardest case to reach from the ports is a timer equality that is already pending when the unit wakes from sleep. The equality must be ignored while sleep is high and must then be acted upon exactly once after wake. The stimulus holds tmr_i at the compare value for several cycles with sleep high and confirms that nothing moves. It also issues a mode write during sleep to show that the write is dropped. It then releases sleep with the equality still present and expects a single event. A second case holds the equality across several cycles while awake, to show that the trigger pulse is not repeated.

// File: rtl/cmp_unit_pkg.sv
package cmp_unit_pkg;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd2;

  typedef enum logic [2:0] {
    MD_OFF,
    MD_SET_HI,
    MD_SET_LO,
    MD_SOFT,
    MD_TRIG
  } mode_e;

  function automatic mode_e decode_mode(input logic [MODE_W-1:0] code);
    case (code)
      4'b1000: decode_mode = MD_SET_HI;
      4'b1001: decode_mode = MD_SET_LO;
      4'b1010: decode_mode = MD_SOFT;
      4'b1011: decode_mode = MD_TRIG;
      default: decode_mode = MD_OFF;
    endcase
  endfunction
endpackage

// File: rtl/cmp_unit_regs.sv
module cmp_unit_regs
  import cmp_unit_pkg::*;
#(
  parameter int unsigned TW = TMR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TW-1:0]     wr_data_i,
  output mode_e             mode_o,
  output mode_e             mode_nxt_o,
  output logic              mode_we_o,
  output logic [TW-1:0]     cmp_o,
  output logic              flag_clr_o
);
  logic  wr_ok;
  mode_e mode_q;
  logic [TW-1:0] cmp_q;

  assign wr_ok      = wr_en_i && !sleep_i;
  assign mode_we_o  = wr_ok && (wr_addr_i == ADDR_MODE);
  assign mode_nxt_o = decode_mode(wr_data_i[MODE_W-1:0]);
  assign flag_clr_o = wr_ok && (wr_addr_i == ADDR_CLR) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_OFF;
      cmp_q  <= '0;
    end else begin
      if (mode_we_o) mode_q <= mode_nxt_o;
      if (wr_ok && (wr_addr_i == ADDR_CMP)) cmp_q <= wr_data_i;
    end
  end

  assign mode_o = mode_q;
  assign cmp_o  = cmp_q;

  a_r10_no_write_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(mode_q) && $stable(cmp_q)));
endmodule

// File: rtl/cmp_unit_match.sv
module cmp_unit_match
  import cmp_unit_pkg::*;
#(
  parameter int unsigned TW = TMR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  mode_e         mode_i,
  input  logic [TW-1:0] tmr_i,
  input  logic [TW-1:0] cmp_i,
  output logic          evt_o
);
  logic eq_now, eq_q;

  assign eq_now = (mode_i != MD_OFF) && (tmr_i == cmp_i) && !sleep_i;

  // equality held across sleep so wake does not replay a seen match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       eq_q <= 1'b0;
    else if (!sleep_i) eq_q <= eq_now;
  end

  assign evt_o = eq_now && !eq_q;

  a_r9_single_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/cmp_unit_out.sv
module cmp_unit_out
  import cmp_unit_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_i,
  input  mode_e mode_i,
  input  mode_e mode_nxt_i,
  input  logic  mode_we_i,
  input  logic  evt_i,
  input  logic  flag_clr_i,
  input  logic  adc_en_i,
  output logic  cmp_out_o,
  output logic  irq_flag_o,
  output logic  tmr_clr_o,
  output logic  adc_start_o
);
  logic out_q, out_d, flag_q, clr_q, adc_q;

  always_comb begin
    out_d = out_q;
    if (mode_we_i) begin
      case (mode_nxt_i)
        MD_SET_HI: out_d = 1'b0;
        MD_SET_LO: out_d = 1'b1;
        MD_OFF:    out_d = 1'b0;
        default:   out_d = out_q;
      endcase
    end else if (evt_i) begin
      case (mode_i)
        MD_SET_HI: out_d = 1'b1;
        MD_SET_LO: out_d = 1'b0;
        default:   out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
      adc_q  <= 1'b0;
    end else if (!sleep_i) begin
      out_q <= out_d;
      if (evt_i)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      clr_q <= evt_i && (mode_i == MD_TRIG);
      adc_q <= evt_i && (mode_i == MD_TRIG) && adc_en_i;
    end else begin
      clr_q <= 1'b0;
      adc_q <= 1'b0;
    end
  end

  assign cmp_out_o   = out_q;
  assign irq_flag_o  = flag_q;
  assign tmr_clr_o   = clr_q;
  assign adc_start_o = adc_q;

  a_r5_clr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q);
  a_r6_adc_with_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_q |-> clr_q);
  a_r8_flag_on_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> flag_q);
  a_r7_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_OFF) |-> !out_q);
  a_r10_hold_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(out_q) && $stable(flag_q)));
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit
  import cmp_unit_pkg::*;
#(
  parameter int unsigned TW = TMR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TW-1:0]     wr_data_i,
  input  logic [TW-1:0]     tmr_i,
  input  logic              adc_en_i,
  output logic              tmr_clr_o,
  output logic              adc_start_o,
  output logic              irq_flag_o,
  output logic              cmp_out_o
);
  mode_e         mode, mode_nxt;
  logic          mode_we, flag_clr, evt;
  logic [TW-1:0] cmp;

  cmp_unit_regs #(.TW(TW)) u_regs (
    .clk_i, .rst_ni, .sleep_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .mode_nxt_o(mode_nxt), .mode_we_o(mode_we),
    .cmp_o(cmp), .flag_clr_o(flag_clr)
  );

  cmp_unit_match #(.TW(TW)) u_match (
    .clk_i, .rst_ni, .sleep_i, .mode_i(mode), .tmr_i, .cmp_i(cmp), .evt_o(evt)
  );

  cmp_unit_out u_out (
    .clk_i, .rst_ni, .sleep_i, .mode_i(mode), .mode_nxt_i(mode_nxt),
    .mode_we_i(mode_we), .evt_i(evt), .flag_clr_i(flag_clr), .adc_en_i,
    .cmp_out_o, .irq_flag_o, .tmr_clr_o, .adc_start_o
  );
endmodule

// File: tb/cmp_unit_bench.sv
module cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] tmr_i = 16'h7777;
  logic        adc_en_i = 1'b0;
  logic        tmr_clr_o, adc_start_o, irq_flag_o, cmp_out_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmp_unit u_cmp_unit (
    .clk_i(clk), .rst_ni, .sleep_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tmr_i, .adc_en_i, .tmr_clr_o, .adc_start_o, .irq_flag_o, .cmp_out_o
  );

  typedef struct packed {
    logic [3:0]  pre;
    logic [3:0]  mode;
    logic [15:0] cmp;
    logic        adc;
    logic        e_pre;
    logic        e_out;
    logic        e_flag;
    logic        e_trig;
    logic        e_adc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 4'h8, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    '{4'h0, 4'h9, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R3
    '{4'h9, 4'hA, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R4
    '{4'h8, 4'hA, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    '{4'h9, 4'hB, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 R6
    '{4'h0, 4'hB, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 R6
    '{4'h8, 4'h5, 16'h0042, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R7
    '{4'h9, 4'h0, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R7
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 out", cmp_out_o, 1'b0);
    chk("R1 flag", irq_flag_o, 1'b0);
    chk("R1 clr", tmr_clr_o, 1'b0);
    chk("R1 adc", adc_start_o, 1'b0);
    rst_ni = 1'b1;
    tick(1);
    // mode off after reset: compare at 0 matches nothing
    tmr_i = 16'h0000;
    tick(2);
    chk("R1 off no flag", irq_flag_o, 1'b0);
    tmr_i = 16'h7777;

    for (int v = 0; v < NV; v++) begin
      tmr_i = VECS[v].cmp ^ 16'h8001;
      adc_en_i = VECS[v].adc;
      wr(2'd0, {12'h0, VECS[v].pre});
      wr(2'd0, {12'h0, VECS[v].mode});
      wr(2'd1, VECS[v].cmp);
      wr(2'd2, 16'h0001);
      chk($sformatf("R2/R3/R4/R7 preset v%0d", v), cmp_out_o, VECS[v].e_pre);
      chk($sformatf("R8 flag idle v%0d", v), irq_flag_o, 1'b0);
      tmr_i = VECS[v].cmp;
      tick(1);
      chk($sformatf("R2/R3/R4/R7 match out v%0d", v), cmp_out_o, VECS[v].e_out);
      chk($sformatf("R8 flag v%0d", v), irq_flag_o, VECS[v].e_flag);
      chk($sformatf("R5 clr v%0d", v), tmr_clr_o, VECS[v].e_trig);
      chk($sformatf("R6 adc v%0d", v), adc_start_o, VECS[v].e_adc);
      tmr_i = VECS[v].cmp ^ 16'h8001;
      tick(1);
      chk($sformatf("R5 clr end v%0d", v), tmr_clr_o, 1'b0);
    end

    // R8: write-one-to-clear, zero ignored, set beats clear
    wr(2'd0, 16'h000A);
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h0001);
    tmr_i = 16'h0100;
    tick(1);
    tmr_i = 16'h0200;
    chk("R8 set", irq_flag_o, 1'b1);
    wr(2'd2, 16'h0000);
    chk("R8 zero write keeps", irq_flag_o, 1'b1);
    wr(2'd2, 16'h0001);
    chk("R8 clear", irq_flag_o, 1'b0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 16'h0001; tmr_i = 16'h0100;
    @(negedge clk);
    wr_en_i = 1'b0; tmr_i = 16'h0200;
    chk("R8 set wins", irq_flag_o, 1'b1);

    // R9: equality held several cycles gives one pulse
    wr(2'd0, 16'h000B);
    adc_en_i = 1'b1;
    tmr_i = 16'h0100;
    tick(1);
    chk("R9 first pulse", tmr_clr_o, 1'b1);
    tick(1);
    chk("R9 no repeat clr", tmr_clr_o, 1'b0);
    chk("R9 no repeat adc", adc_start_o, 1'b0);
    tick(2);
    chk("R9 still quiet", tmr_clr_o, 1'b0);
    tmr_i = 16'h0200;

    // R10: sleep with pending equality, write dropped, wake resumes
    wr(2'd0, 16'h0008);
    wr(2'd2, 16'h0001);
    chk("R2 preset low", cmp_out_o, 1'b0);
    @(negedge clk);
    sleep_i = 1'b1; tmr_i = 16'h0100;
    tick(3);
    chk("R10 out held", cmp_out_o, 1'b0);
    chk("R10 flag held", irq_flag_o, 1'b0);
    wr(2'd0, 16'h0009);
    chk("R10 write ignored", cmp_out_o, 1'b0);
    sleep_i = 1'b0;
    tick(1);
    chk("R10 wake match", cmp_out_o, 1'b1);
    chk("R10 wake flag", irq_flag_o, 1'b1);
    tmr_i = 16'h0200;
    @(negedge clk);
    sleep_i = 1'b1;
    wr(2'd0, 16'h0000);
    tick(1);
    chk("R10 drive kept asleep", cmp_out_o, 1'b1);
    sleep_i = 1'b0;
    wr(2'd0, 16'h0000);
    chk("R7 off forces low", cmp_out_o, 1'b0);

    // R1: reset mid-operation
    wr(2'd0, 16'h0009);
    chk("R3 preset high", cmp_out_o, 1'b1);
    rst_ni = 1'b0;
    tick(1);
    chk("R1 reset out", cmp_out_o, 1'b0);
    chk("R1 reset flag", irq_flag_o, 1'b0);
    rst_ni = 1'b1;
    tmr_i = 16'h0000;
    tick(2);
    chk("R1 off after reset", irq_flag_o, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule